// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Manager

This block moves outgoing packets from memory to a MAC transmit datapath. Software places transmit descriptors in a ring in memory and advances a produce index. The block owns a consume index and follows the ring from that index. For each descriptor it fetches two words: a buffer address and a control word. It reads the buffer and sends its bytes as a byte stream. A packet may span several descriptors, and a per-descriptor end-of-packet flag marks the final one. Each frame carries two request flags to the MAC: append a checksum, and pad a short frame.

Two independent queues exist: a normal queue and a real-time queue. Each has its own descriptor base, status base, ring size and index pair. When both queues hold work, the real-time queue is chosen, but only at a packet boundary. After the last byte of a packet, the block writes a status word and a timestamp word to the status ring. Only then does it advance the consume index. It then sets interrupt flags, which pass through a mask to a single interrupt line.

Clearing a queue's enable never cuts a packet short. A packet already started is finished and its status written, and then the queue goes quiet.

Top module: `txring_dma`

## Requirements
- R1: After reset every register reads 0, `mem_req` and `tx_valid` are low and `irq` is low.
- R2: The block fetches descriptor i of a queue at descriptor base + 8·i (word 0: buffer address) and +4 (word 1: control). Control word bits are: [10:0] byte count minus one, bit 28 pad request, bit 29 checksum request, bit 30 end of packet, bit 31 interrupt request. On a word-0 fetch, `mem_blen` gives the number of descriptors the hardware owns from the fetched index up to the produce index.
- R3: Indices wrap to 0 after the programmed last index. The owned count is produce − consume, taken modulo the ring size.
- R4: Fragment bytes go out in order, lowest address first, from any byte alignment. Fragments chain until a descriptor with the end-of-packet bit. `tx_last` is high only on the final byte of that descriptor.
- R5: `tx_crc` and `tx_pad` hold the first descriptor's request bits on every byte of the frame.
- R6: After a packet, the block writes two words at status base + 8·(index of last descriptor). Word 0 holds {8'h0, fragment count[7:0], byte count[15:0]}. Word 1 holds a free-running timestamp. The consume index moves past the packet only after both writes are acknowledged.
- R7: A queue's active bit reads 1 when the queue is enabled and owns descriptors, or while its packet is in flight. Otherwise it reads 0.
- R8: When a consume advance empties a ring, that queue's finished flag is set and its enable bit stays as written.
- R9: A queue's done flag is set at the consume advance if any descriptor of the packet had the interrupt bit set.
- R10: Clearing an enable bit mid-packet still sends the rest of the packet, writes its status and advances the index. No further packet of that queue starts.
- R11: With both queues pending at a packet boundary, the real-time queue goes first. A packet already started is never interleaved with the other queue, even while it waits for its next fragment to be posted.
- R12: Flags are at bit 2q (done) and 2q+1 (finished), with q=0 for normal and q=1 for real-time. `irq` is the OR of flags ANDed with the enable mask. Writing 1 to the clear register drops a flag. A set in the same cycle wins over a clear.
- R13: While `tx_valid` is high and `tx_ready` is low, the data and flags on the stream stay stable.

Register map (word address on `reg_addr`):
- 0: enables (bit 0 normal, bit 1 real-time)
- 1: active bits (read-only)
- 2: interrupt mask
- 3: flags (read-only)
- 4: flag clear (write 1 to clear)
- 8–12: normal queue — descriptor base, status base, last index, produce index, consume index (read-only)
- 16–20: real-time queue, same layout

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_blen | output | 8 | Descriptors owned ahead of a descriptor fetch |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_crc | output | 1 | Frame wants checksum appended |
| tx_pad | output | 1 | Frame wants short-frame padding |
| irq | output | 1 | Masked interrupt |

## Verification
The two functions that can share a cycle are a status commit setting an interrupt flag and a software write to the clear register. The bench watches the memory port for the acknowledged timestamp write of a real-time packet. It then drives the clear write in the next cycle, which is exactly the cycle in which the consume index advances and the flags are set. It judges the outcome by reading back the flags: the freshly set bits must survive. A second, isolated clear must then remove them.

// File: rtl/txring_pkg.sv
package txring_pkg;
   localparam int CF_IRQ  = 31;
   localparam int CF_LAST = 30;
   localparam int CF_CRC  = 29;
   localparam int CF_PAD  = 28;
   localparam int CF_SZW  = 11;

   localparam logic [2:0] RA_ENABLE = 3'd0;
   localparam logic [2:0] RA_ACTIVE = 3'd1;
   localparam logic [2:0] RA_MASK   = 3'd2;
   localparam logic [2:0] RA_FLAGS  = 3'd3;
   localparam logic [2:0] RA_CLEAR  = 3'd4;

   localparam logic [2:0] QA_DBASE = 3'd0;
   localparam logic [2:0] QA_SBASE = 3'd1;
   localparam logic [2:0] QA_LAST  = 3'd2;
   localparam logic [2:0] QA_PROD  = 3'd3;
   localparam logic [2:0] QA_CONS  = 3'd4;

   typedef enum logic [2:0] {
      S_IDLE, S_D0, S_D1, S_DATA, S_EMIT, S_ST0, S_ST1, S_ADV
   } txring_state_e;
endpackage

// File: rtl/txring_queue.sv
module txring_queue
   import txring_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 8,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_idx,
   input  logic [DW-1:0] wdata,
   input  logic          adv,
   input  logic [IW-1:0] adv_idx,
   input  logic [2:0]    rd_idx,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] dbase,
   output logic [AW-1:0] sbase,
   output logic [IW-1:0] last,
   output logic [IW-1:0] prod,
   output logic [IW-1:0] cons,
   output logic [IW-1:0] owned
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dbase <= '0;
         sbase <= '0;
         last  <= '0;
         prod  <= '0;
         cons  <= '0;
      end else begin
         if (wr_en) begin
            case (wr_idx)
               QA_DBASE: dbase <= wdata[AW-1:0];
               QA_SBASE: sbase <= wdata[AW-1:0];
               QA_LAST:  last  <= wdata[IW-1:0];
               QA_PROD:  prod  <= wdata[IW-1:0];
               default: ;
            endcase
         end
         if (adv) cons <= adv_idx;
      end
   end

   // modular distance around a ring of (last + 1) slots
   assign owned = prod - cons + ((prod < cons) ? (last + IW'(1)) : '0);

   always_comb begin
      case (rd_idx)
         QA_DBASE: rd_data = DW'(dbase);
         QA_SBASE: rd_data = DW'(sbase);
         QA_LAST:  rd_data = DW'(last);
         QA_PROD:  rd_data = DW'(prod);
         QA_CONS:  rd_data = DW'(cons);
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txring_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DATA_BYTES = 4,
   parameter int IW         = 8,
   localparam int DW        = 8 * DATA_BYTES,
   localparam int LW        = $clog2(DATA_BYTES),
   localparam int SH        = $clog2(2 * DATA_BYTES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          go_i,
   input  logic [1:0][AW-1:0]  dbase_i,
   input  logic [1:0][AW-1:0]  sbase_i,
   input  logic [1:0][IW-1:0]  last_i,
   input  logic [1:0][IW-1:0]  prod_i,
   input  logic [1:0][IW-1:0]  cons_i,
   input  logic [DW-1:0]       stamp_i,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   output logic [IW-1:0]       mem_blen,
   input  logic                mem_ack,
   input  logic [DW-1:0]       mem_rdata,
   output logic                tx_valid,
   input  logic                tx_ready,
   output logic [7:0]          tx_data,
   output logic                tx_last,
   output logic                tx_crc,
   output logic                tx_pad,
   output logic                adv_o,
   output logic                adv_q,
   output logic [IW-1:0]       adv_idx,
   output logic                done_o,
   output logic                fin_o,
   output logic                busy_o
);
   txring_state_e st;
   logic          q;
   logic [IW-1:0] walk, sidx;
   logic [AW-1:0] paddr;
   logic [DW-1:0] word, stamp_r;
   logic [LW-1:0] lane;
   logic [CF_SZW:0] rem;
   logic [15:0]   nbytes;
   logic [7:0]    nfrag;
   logic          lastf, crcf, padf, irqf;

   logic [IW-1:0] c_prod, c_last;
   logic [AW-1:0] c_dbase, c_sbase;
   logic          ack;

   assign c_prod  = prod_i[q];
   assign c_last  = last_i[q];
   assign c_dbase = dbase_i[q];
   assign c_sbase = sbase_i[q];
   assign ack     = mem_req && mem_ack;

   function automatic logic [IW-1:0] step(input logic [IW-1:0] i, input logic [IW-1:0] l);
      return (i >= l) ? '0 : i + IW'(1);
   endfunction

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      mem_blen  = '0;
      case (st)
         S_D0: begin
            mem_req  = (walk != c_prod);
            mem_addr = c_dbase + (AW'(walk) << SH);
            mem_blen = c_prod - walk + ((c_prod < walk) ? (c_last + IW'(1)) : '0);
         end
         S_D1: begin
            mem_req  = 1'b1;
            mem_addr = c_dbase + (AW'(walk) << SH) + AW'(DATA_BYTES);
         end
         S_DATA: begin
            mem_req  = 1'b1;
            mem_addr = paddr & ~AW'(DATA_BYTES - 1);
         end
         S_ST0: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = c_sbase + (AW'(sidx) << SH);
            mem_wdata[23:0] = {nfrag, nbytes};
         end
         S_ST1: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = c_sbase + (AW'(sidx) << SH) + AW'(DATA_BYTES);
            mem_wdata = stamp_r;
         end
         default: ;
      endcase
   end

   assign tx_valid = (st == S_EMIT);
   assign tx_data  = word[{lane, 3'b000} +: 8];
   assign tx_last  = tx_valid && lastf && (rem == (CF_SZW+1)'(1));
   assign tx_crc   = tx_valid && crcf;
   assign tx_pad   = tx_valid && padf;

   assign adv_o   = (st == S_ADV);
   assign adv_q   = q;
   assign adv_idx = walk;
   assign done_o  = adv_o && irqf;
   assign fin_o   = adv_o && (walk == c_prod);
   assign busy_o  = (st != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_IDLE;
         q <= 1'b0;
         walk <= '0;
         sidx <= '0;
         paddr <= '0;
         word <= '0;
         stamp_r <= '0;
         lane <= '0;
         rem <= '0;
         nbytes <= '0;
         nfrag <= '0;
         {lastf, crcf, padf, irqf} <= '0;
      end else begin
         case (st)
            S_IDLE: if (|go_i) begin
               q      <= go_i[1];
               walk   <= go_i[1] ? cons_i[1] : cons_i[0];
               nbytes <= '0;
               nfrag  <= '0;
               irqf   <= 1'b0;
               st     <= S_D0;
            end
            S_D0: if (ack) begin
               paddr <= mem_rdata[AW-1:0];
               st    <= S_D1;
            end
            S_D1: if (ack) begin
               rem   <= {1'b0, mem_rdata[CF_SZW-1:0]} + (CF_SZW+1)'(1);
               lastf <= mem_rdata[CF_LAST];
               irqf  <= irqf | mem_rdata[CF_IRQ];
               if (nfrag == 8'd0) begin
                  crcf <= mem_rdata[CF_CRC];
                  padf <= mem_rdata[CF_PAD];
               end
               st <= S_DATA;
            end
            S_DATA: if (ack) begin
               word <= mem_rdata;
               lane <= paddr[LW-1:0];
               st   <= S_EMIT;
            end
            S_EMIT: if (tx_ready) begin
               rem    <= rem - (CF_SZW+1)'(1);
               nbytes <= nbytes + 16'd1;
               lane   <= lane + LW'(1);
               if (rem == (CF_SZW+1)'(1)) begin
                  nfrag <= nfrag + 8'd1;
                  sidx  <= walk;
                  walk  <= step(walk, c_last);
                  if (lastf) begin
                     stamp_r <= stamp_i;
                     st      <= S_ST0;
                  end else begin
                     st <= S_D0;
                  end
               end else if (&lane) begin
                  paddr <= (paddr & ~AW'(DATA_BYTES - 1)) + AW'(DATA_BYTES);
                  st    <= S_DATA;
               end
            end
            S_ST0: if (ack) st <= S_ST1;
            S_ST1: if (ack) st <= S_ADV;
            default: st <= S_IDLE;
         endcase
      end
   end

   assert_stream_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)
                                    && $stable(tx_crc) && $stable(tx_pad)));

   assert_advance_after_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adv_o |-> $past(mem_req && mem_we && mem_ack));

   assert_no_interleave_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(q));

   assert_ready_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && st == S_D0) |-> (mem_blen != '0));
endmodule

// File: rtl/txring_dma.sv
module txring_dma
   import txring_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DATA_BYTES = 4,
   parameter int IW         = 8,
   parameter bit STAMP_EN   = 1'b1,
   localparam int DW        = 8 * DATA_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [4:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [IW-1:0] mem_blen,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          tx_valid,
   input  logic          tx_ready,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   output logic          tx_crc,
   output logic          tx_pad,
   output logic          irq
);
   if (DATA_BYTES < 4 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("DATA_BYTES must be a power of two of at least 4");
   end
   if (AW > DW || AW < 8) begin : g_bad_aw
      $error("AW must lie between 8 and the data width");
   end
   if (IW < 1 || IW > 16) begin : g_bad_iw
      $error("IW must lie between 1 and 16");
   end

   logic [1:0]          en;
   logic [3:0]          mask, flags, set_v, clr_v;
   logic [1:0][AW-1:0]  dbase, sbase;
   logic [1:0][IW-1:0]  last, prod, cons, owned;
   logic [1:0][DW-1:0]  q_rd;
   logic [1:0]          go, active;
   logic                adv, adv_q, done, fin, busy;
   logic [IW-1:0]       adv_idx;
   logic [DW-1:0]       stamp;
   logic                glob_wr;

   assign glob_wr = reg_we && (reg_addr[4:3] == 2'd0);

   for (genvar k = 0; k < 2; k++) begin : g_q
      txring_queue #(.AW(AW), .IW(IW), .DW(DW)) u_q (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && reg_addr[4:3] == 2'(k + 1)),
         .wr_idx  (reg_addr[2:0]),
         .wdata   (reg_wdata),
         .adv     (adv && adv_q == 1'(k)),
         .adv_idx (adv_idx),
         .rd_idx  (reg_addr[2:0]),
         .rd_data (q_rd[k]),
         .dbase   (dbase[k]),
         .sbase   (sbase[k]),
         .last    (last[k]),
         .prod    (prod[k]),
         .cons    (cons[k]),
         .owned   (owned[k])
      );
      assign go[k]        = en[k] && (owned[k] != '0);
      assign active[k]    = go[k] || (busy && adv_q == 1'(k));
      assign set_v[2*k]   = done && adv_q == 1'(k);
      assign set_v[2*k+1] = fin && adv_q == 1'(k);
   end

   if (STAMP_EN) begin : g_stamp
      logic [DW-1:0] tick;
      always_ff @(posedge clk) begin
         if (!rst_n) tick <= '0;
         else        tick <= tick + DW'(1);
      end
      assign stamp = tick;
   end else begin : g_nostamp
      assign stamp = '0;
   end

   txring_engine #(.AW(AW), .DATA_BYTES(DATA_BYTES), .IW(IW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (go),
      .dbase_i   (dbase),
      .sbase_i   (sbase),
      .last_i    (last),
      .prod_i    (prod),
      .cons_i    (cons),
      .stamp_i   (stamp),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_blen  (mem_blen),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .tx_data   (tx_data),
      .tx_last   (tx_last),
      .tx_crc    (tx_crc),
      .tx_pad    (tx_pad),
      .adv_o     (adv),
      .adv_q     (adv_q),
      .adv_idx   (adv_idx),
      .done_o    (done),
      .fin_o     (fin),
      .busy_o    (busy)
   );

   assign clr_v = (glob_wr && reg_addr[2:0] == RA_CLEAR) ? reg_wdata[3:0] : 4'h0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= '0;
         mask  <= '0;
         flags <= '0;
      end else begin
         if (glob_wr && reg_addr[2:0] == RA_ENABLE) en   <= reg_wdata[1:0];
         if (glob_wr && reg_addr[2:0] == RA_MASK)   mask <= reg_wdata[3:0];
         flags <= (flags & ~clr_v) | set_v;
      end
   end

   assign irq = |(flags & mask);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr[4:3])
         2'd0: case (reg_addr[2:0])
            RA_ENABLE: reg_rdata = DW'(en);
            RA_ACTIVE: reg_rdata = DW'(active);
            RA_MASK:   reg_rdata = DW'(mask);
            RA_FLAGS:  reg_rdata = DW'(flags);
            default:   reg_rdata = '0;
         endcase
         2'd1: reg_rdata = q_rd[0];
         2'd2: reg_rdata = q_rd[1];
         default: reg_rdata = '0;
      endcase
   end

   assert_set_beats_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> ((flags & $past(set_v)) == $past(set_v)));

   assert_fin_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v[1] || set_v[3]) |=> (owned[$past(adv_q)] == '0 || $past(reg_we)));
endmodule

// File: tb/txring_dma_test.sv
module txring_dma_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [7:0]  mem_blen;
   logic        tx_valid, tx_last, tx_crc, tx_pad, irq;
   logic        tx_ready = 1'b1;
   logic [7:0]  tx_data;

   logic [31:0] mem [0:1023];
   logic [7:0]  cap_data [0:63];
   logic        cap_last [0:63];
   logic        cap_crc  [0:63];
   logic        cap_pad  [0:63];
   int          cap_n = 0;
   int          n_run = 0;
   int          n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   txring_dma uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_blen(mem_blen), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_last(tx_last), .tx_crc(tx_crc), .tx_pad(tx_pad), .irq(irq)
   );

   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[11:2]];

   always @(posedge clk) begin
      if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
      if (tx_valid && tx_ready && cap_n < 64) begin
         cap_data[cap_n] <= tx_data;
         cap_last[cap_n] <= tx_last;
         cap_crc[cap_n]  <= tx_crc;
         cap_pad[cap_n]  <= tx_pad;
         cap_n <= cap_n + 1;
      end
   end

   function automatic logic [7:0] bval(input int a);
      return 8'((a * 13) ^ (a >> 5));
   endfunction

   function automatic logic [31:0] ctl(input int size, input bit ir, input bit la,
                                       input bit cr, input bit pa);
      return {ir, la, cr, pa, 17'd0, 11'(size - 1)};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(input int base, input int idx, input int pa, input logic [31:0] c);
      mem[(base + idx * 8) >> 2]     = pa;
      mem[(base + idx * 8 + 4) >> 2] = c;
   endtask

   task automatic wait_reg(input logic [4:0] a, input logic [31:0] v, input string tag);
      logic [31:0] d;
      d = '0;
      for (int i = 0; i < 400; i++) begin
         reg_read(a, d);
         if (d == v) break;
      end
      check(tag, d, v);
   endtask

   task automatic check_frag(input int at, input int pa, input int len, input string tag);
      int bad;
      bad = 0;
      for (int i = 0; i < len; i++) if (cap_data[at + i] !== bval(pa + i)) bad++;
      check(tag, bad, 0);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      logic [31:0] acc;
      acc = '0;
      for (int a = 0; a < 21; a++) begin
         reg_read(5'(a), d);
         acc = acc | d;
      end
      check("R1 registers zero", acc, 0);
      check("R1 outputs idle", {mem_req, tx_valid, irq}, 3'b000);
   endtask

   task automatic t_single;
      logic [31:0] d;
      cap_n = 0;
      put_desc(32'h100, 0, 32'h800, ctl(6, 1, 1, 1, 0));
      reg_write(5'd11, 1);
      reg_write(5'd0, 1);
      do @(negedge clk); while (!mem_req);
      check("R2 first fetch address", mem_addr, 32'h100);
      check("R2 burst hint one", mem_blen, 1);
      do @(negedge clk); while (!(mem_req && mem_we));
      check("R6 status address", mem_addr, 32'h200);
      check("R6 status word", mem_wdata, 32'h0001_0006);
      reg_addr = 5'd12;
      #1 check("R6 consume held during writeback", reg_rdata, 0);
      wait_reg(5'd12, 1, "R6 consume advanced");
      check("R4 byte count", cap_n, 6);
      check_frag(0, 32'h800, 6, "R4 single fragment bytes");
      check("R4 last marks", {cap_last[0], cap_last[4], cap_last[5]}, 3'b001);
      check("R5 flags crc=1 pad=0", {cap_crc[0], cap_pad[0], cap_crc[5], cap_pad[5]}, 4'b1010);
      reg_read(5'd3, d);
      check("R9 R8 done and finished flags", d, 32'h3);
      check("R12 irq with mask", irq, 1'b1);
      reg_read(5'd1, d);
      check("R7 active low when empty", d, 0);
      reg_read(5'd0, d);
      check("R8 enable kept", d, 1);
      reg_write(5'd4, 32'h3);
      reg_read(5'd3, d);
      check("R12 write-one clear", d, 0);
      check("R12 irq dropped", irq, 1'b0);
   endtask

   task automatic t_chain_wrap;
      logic [31:0] d;
      cap_n = 0;
      put_desc(32'h100, 1, 32'h900, ctl(5, 0, 0, 0, 1));
      put_desc(32'h100, 2, 32'h920, ctl(3, 0, 0, 1, 0));
      put_desc(32'h100, 3, 32'h943, ctl(4, 0, 1, 1, 0));
      reg_write(5'd11, 0);
      do @(negedge clk); while (!mem_req);
      check("R2 R3 wrapped burst hint", mem_blen, 3);
      check("R2 fetch at index one", mem_addr, 32'h108);
      wait_reg(5'd12, 0, "R3 consume wraps to zero");
      check("R4 chained byte count", cap_n, 12);
      check_frag(0, 32'h900, 5, "R4 fragment one");
      check_frag(5, 32'h920, 3, "R4 fragment two");
      check_frag(8, 32'h943, 4, "R4 unaligned fragment three");
      check("R4 single last", {cap_last[4], cap_last[7], cap_last[10], cap_last[11]}, 4'b0001);
      check("R5 first descriptor flags kept", {cap_pad[11], cap_crc[11]}, 2'b10);
      check("R6 chain status", mem[32'h218 >> 2], 32'h0003_000C);
      check("R6 stamp advances", (mem[32'h21C >> 2] > mem[32'h204 >> 2]) ? 1 : 0, 1);
      reg_read(5'd3, d);
      check("R9 no done without interrupt bit", d, 32'h2);
      reg_write(5'd4, 32'hF);
   endtask

   task automatic t_priority;
      logic [31:0] d;
      cap_n = 0;
      put_desc(32'h100, 0, 32'hA00, ctl(4, 0, 0, 0, 0));
      put_desc(32'h100, 1, 32'hA10, ctl(3, 0, 1, 0, 0));
      reg_write(5'd11, 1);
      for (int i = 0; i < 30; i++) @(negedge clk);
      check("R11 first fragment sent", cap_n, 4);
      put_desc(32'h300, 0, 32'hB00, ctl(2, 1, 1, 0, 0));
      reg_write(5'd19, 1);
      reg_write(5'd0, 3);
      for (int i = 0; i < 30; i++) @(negedge clk);
      check("R11 no interleave while waiting", cap_n, 4);
      reg_write(5'd11, 2);
      wait_reg(5'd20, 1, "R11 real-time consumed");
      check("R11 stream length", cap_n, 9);
      check_frag(4, 32'hA10, 3, "R11 normal packet completed first");
      check_frag(7, 32'hB00, 2, "R11 real-time after boundary");
      check("R11 last positions", {cap_last[6], cap_last[7], cap_last[8]}, 3'b101);
      reg_read(5'd3, d);
      check("R9 R8 flag positions", d, 32'hE);
      reg_write(5'd4, 32'hF);
      cap_n = 0;
      reg_write(5'd0, 0);
      put_desc(32'h100, 2, 32'hC00, ctl(2, 0, 1, 0, 0));
      put_desc(32'h300, 1, 32'hC40, ctl(2, 0, 1, 0, 0));
      reg_write(5'd11, 3);
      reg_write(5'd19, 0);
      reg_write(5'd0, 3);
      wait_reg(5'd12, 3, "R11 normal done after");
      check_frag(0, 32'hC40, 2, "R11 real-time wins boundary");
      check_frag(2, 32'hC00, 2, "R11 normal follows");
      reg_read(5'd20, d);
      check("R3 real-time ring wrap", d, 0);
      reg_write(5'd4, 32'hF);
   endtask

   task automatic t_drain;
      logic [31:0] d;
      cap_n = 0;
      tx_ready = 1'b0;
      reg_write(5'd0, 1);
      put_desc(32'h100, 3, 32'hD00, ctl(8, 0, 1, 0, 0));
      put_desc(32'h100, 0, 32'hD20, ctl(2, 0, 1, 0, 0));
      reg_write(5'd11, 1);
      do @(negedge clk); while (!tx_valid);
      reg_write(5'd0, 0);
      @(negedge clk);
      check("R13 byte held under stall", tx_data, bval(32'hD00));
      tx_ready = 1'b1;
      for (int i = 0; i < 80; i++) @(negedge clk);
      check("R10 in-flight packet finished", cap_n, 8);
      check_frag(0, 32'hD00, 8, "R10 drained bytes");
      check("R10 drained status", mem[32'h218 >> 2], 32'h0001_0008);
      reg_read(5'd12, d);
      check("R10 consume past drained packet only", d, 0);
      reg_read(5'd1, d);
      check("R7 inactive when disabled", d, 0);
      reg_write(5'd0, 1);
      wait_reg(5'd12, 1, "R10 pending packet resumes");
      reg_write(5'd4, 32'hF);
   endtask

   task automatic t_mask_collide;
      logic [31:0] d;
      reg_write(5'd2, 32'h2);
      put_desc(32'h300, 0, 32'hE00, ctl(1, 1, 1, 0, 0));
      reg_write(5'd19, 1);
      reg_write(5'd0, 2);
      wait_reg(5'd20, 1, "R12 rt packet consumed");
      reg_read(5'd3, d);
      check("R12 flags set under mask", d, 32'hC);
      check("R12 masked irq low", irq, 1'b0);
      reg_write(5'd2, 32'h4);
      @(negedge clk);
      check("R12 unmasked irq high", irq, 1'b1);
      reg_write(5'd4, 32'hC);
      put_desc(32'h300, 1, 32'hE10, ctl(1, 1, 1, 0, 0));
      reg_write(5'd19, 0);
      do @(negedge clk); while (!(mem_req && mem_we && mem_addr == 32'h38C));
      reg_write(5'd4, 32'hC);
      reg_read(5'd3, d);
      check("R12 set wins same-cycle clear", d, 32'hC);
      reg_write(5'd4, 32'hC);
      reg_read(5'd3, d);
      check("R12 isolated clear", d, 0);
   endtask

   initial begin
      for (int w = 0; w < 1024; w++) mem[w] = '0;
      for (int w = 512; w < 1024; w++)
         mem[w] = {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      reg_write(5'd8, 32'h100);
      reg_write(5'd9, 32'h200);
      reg_write(5'd10, 3);
      reg_write(5'd16, 32'h300);
      reg_write(5'd17, 32'h380);
      reg_write(5'd18, 1);
      reg_write(5'd2, 32'hF);
      t_single();
      t_chain_wrap();
      t_priority();
      t_drain();
      t_mask_collide();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule